// File: doc/BRIEF.md
# IrDA SIR Start Flag Sequencer

This block opens every infrared SIR frame. A frame begins with a train of filler flag characters followed by one start flag, and this sequencer produces that train, one character at a time, toward the UART character serializer. Software sets the flag count through a write-only 8-bit length register. A one-cycle start strobe launches the sequence. When the start flag has been accepted, a one-cycle done pulse tells the payload path that it may take over.

The programmed count is the total number of flag characters, and the start flag is one of them. A value of N+1 gives N filler flags (0xFF) followed by the start flag (0xC0). The value 1 gives the start flag alone, and the value 0 wraps to 255 filler flags plus the start flag. The count is latched when the start strobe is accepted, so a register write during a sequence takes effect only on the following frame.

The output stream follows valid/ready rules. `flag_valid` rises in the cycle after an accepted start. It stays high with `flag_data` unchanged until a cycle in which `flag_ready` is also high. A character is consumed only in such a cycle. The downstream side may hold `flag_ready` low for any number of cycles; the sequence stalls and no character is lost or repeated.

Top module: `irsir_preamble`

## Requirements
- R1: After reset `flag_valid` and `seq_done` are low, and the latched length is 0.
- R2: A length L in the range 1 to 255 emits L-1 characters of value 0xFF and then exactly one character of value 0xC0, all 0xFF characters first.
- R3: A length of 0 emits 255 characters of value 0xFF followed by one 0xC0.
- R4: The length range covers at least 176 filler flags: a length of 177 emits 176 of them and then the start flag.
- R5: While `flag_valid` is high and `flag_ready` is low, in the next cycle `flag_valid` stays high and `flag_data` is unchanged. The sequence advances only on a cycle in which both are high.
- R6: The length is latched when start is accepted. A register write during an active sequence leaves that sequence unchanged and sets the count for the next one.
- R7: `seq_done` is high for exactly one cycle: the cycle after the 0xC0 handshake. In that cycle `flag_valid` is low and the block is idle.
- R8: A start strobe that arrives while a sequence is active is ignored. The count of the running sequence is unchanged and no second sequence follows.
- R9: `len_rd_data` always reads as zero, including after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_wr_en | input | 1 | Write strobe for the length register |
| len_wr_data | input | 8 | Length value to write |
| len_rd_data | output | 8 | Read value of the length register, always zero |
| seq_start | input | 1 | One-cycle request to begin a flag sequence |
| flag_valid | output | 1 | Flag character is available |
| flag_data | output | 8 | Flag character, 0xFF filler or 0xC0 start flag |
| flag_ready | input | 1 | Serializer accepts the current character |
| seq_done | output | 1 | One-cycle pulse after the start flag handshake |

## Verification
The bench targets the counting edges.

- **Lengths 1, 2, 177, 255 and 0.** An off-by-one design sends one filler too many or too few. A design without the zero wrap sends the start flag alone or nothing for length 0.
- **Back-pressure.** Alternating `flag_ready` shows whether a design advances without a handshake; that design would drop characters or change `flag_data` while stalled.
- **Write during a sequence.** A design that reads the live register would shorten or lengthen the running sequence.
- **Start during a sequence.** A design that honors the strobe would restart the count or chain a second sequence after the done pulse.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam logic [CHAR_W-1:0] XBOF_CODE = 8'hFF;
  localparam logic [CHAR_W-1:0] BOF_CODE  = 8'hC0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/irsir_len_reg.sv
module irsir_len_reg #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LEN_W-1:0] wr_data,
  output logic [LEN_W-1:0] len_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len_q <= '0;
    else if (wr_en) len_q <= wr_data;
  end
endmodule

// File: rtl/irsir_seq_ctrl.sv
module irsir_seq_ctrl
  import irsir_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_q,
  input  logic             ready,
  output logic             valid,
  output logic             last,
  output logic             done
);
  localparam logic [CNT_W-1:0] WRAP_CNT = CNT_W'(1) << LEN_W;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hs;

  assign valid = (state_q == ST_RUN);
  assign last  = (cnt_q == CNT_W'(1));
  assign hs    = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= (len_q == '0) ? WRAP_CNT : {1'b0, len_q};
          end
        end
        ST_RUN: begin
          if (hs) begin
            if (last) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irsir_char_sel.sv
module irsir_char_sel #(
  parameter int unsigned CHAR_W = 8,
  parameter logic [CHAR_W-1:0] FILL_CHAR  = 8'hFF,
  parameter logic [CHAR_W-1:0] START_CHAR = 8'hC0
) (
  input  logic              valid,
  input  logic              last,
  output logic [CHAR_W-1:0] data
);
  always_comb begin
    if (!valid)    data = '0;
    else if (last) data = START_CHAR;
    else           data = FILL_CHAR;
  end
endmodule

// File: rtl/irsir_preamble.sv
module irsir_preamble
  import irsir_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_wr_en,
  input  logic [LEN_W-1:0]  len_wr_data,
  output logic [LEN_W-1:0]  len_rd_data,
  input  logic              seq_start,
  output logic              flag_valid,
  output logic [CHAR_W-1:0] flag_data,
  input  logic              flag_ready,
  output logic              seq_done
);
  logic [LEN_W-1:0] len_q;
  logic             last;

  assign len_rd_data = '0;

  irsir_len_reg #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (len_wr_en),
    .wr_data (len_wr_data),
    .len_q   (len_q)
  );

  irsir_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .len_q (len_q),
    .ready (flag_ready),
    .valid (flag_valid),
    .last  (last),
    .done  (seq_done)
  );

  irsir_char_sel #(
    .CHAR_W     (CHAR_W),
    .FILL_CHAR  (XBOF_CODE),
    .START_CHAR (BOF_CODE)
  ) u_sel (
    .valid (flag_valid),
    .last  (last),
    .data  (flag_data)
  );
endmodule

// File: rtl/irsir_preamble_chk.sv
module irsir_preamble_chk
  import irsir_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              seq_start,
  input logic              flag_valid,
  input logic [CHAR_W-1:0] flag_data,
  input logic              flag_ready,
  input logic              seq_done
);
  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !flag_ready) |=> (flag_valid && $stable(flag_data)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  p_done_after_bof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_ready && flag_data == BOF_CODE) |=> (seq_done && !flag_valid));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !flag_valid);

  p_fill_then_more_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_ready && flag_data == XBOF_CODE) |=> (flag_valid && !seq_done));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !flag_ready && seq_start) |=> $stable(flag_data));

  p_char_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |-> (flag_data == XBOF_CODE || flag_data == BOF_CODE));
endmodule

bind irsir_preamble irsir_preamble_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_start  (seq_start),
  .flag_valid (flag_valid),
  .flag_data  (flag_data),
  .flag_ready (flag_ready),
  .seq_done   (seq_done)
);

// File: tb/irsir_preamble_tb.sv
module irsir_preamble_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       len_wr_en = 1'b0;
  logic [7:0] len_wr_data = '0;
  logic [7:0] len_rd_data;
  logic       seq_start = 1'b0;
  logic       flag_valid;
  logic [7:0] flag_data;
  logic       flag_ready = 1'b0;
  logic       seq_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irsir_preamble u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_wr_en   (len_wr_en),
    .len_wr_data (len_wr_data),
    .len_rd_data (len_rd_data),
    .seq_start   (seq_start),
    .flag_valid  (flag_valid),
    .flag_data   (flag_data),
    .flag_ready  (flag_ready),
    .seq_done    (seq_done)
  );

  // Row fields: wr[28] len[27:20] stall[19] mid_wr[18] mid_val[17:10] mid_start[9] exp_fill[8:0]
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'd1,   1'b0, 1'b0, 8'd0, 1'b0, 9'd0},    // R2 start flag alone
    {1'b1, 8'd2,   1'b0, 1'b0, 8'd0, 1'b0, 9'd1},    // R2
    {1'b1, 8'd5,   1'b1, 1'b0, 8'd0, 1'b0, 9'd4},    // R2 R5 stalls
    {1'b1, 8'd0,   1'b0, 1'b0, 8'd0, 1'b0, 9'd255},  // R3 wrap
    {1'b1, 8'd177, 1'b1, 1'b0, 8'd0, 1'b0, 9'd176},  // R4
    {1'b1, 8'd4,   1'b0, 1'b1, 8'd9, 1'b0, 9'd3},    // R6 write mid-sequence
    {1'b0, 8'd0,   1'b1, 1'b0, 8'd0, 1'b0, 9'd8},    // R6 next frame uses 9
    {1'b1, 8'd3,   1'b1, 1'b0, 8'd0, 1'b1, 9'd2},    // R8 start while busy
    {1'b1, 8'd255, 1'b0, 1'b0, 8'd0, 1'b0, 9'd254}   // R2 top value
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_len(input logic [7:0] v);
    @(negedge clk);
    len_wr_en = 1'b1; len_wr_data = v;
    @(negedge clk);
    len_wr_en = 1'b0;
    check(len_rd_data == 8'h00, "R9", len_rd_data, 0);
  endtask

  task automatic run_frame(input bit stall, input bit mwr, input logic [7:0] mval,
                           input bit mst, input int exp_fill, input string req);
    int  nfill = 0;
    bit  got_bof = 0;
    bit  order_bad = 0;
    bit  hold_bad = 0;
    bit  early_done = 0;
    bit  prev_wait = 0;
    logic [7:0] prev_data = '0;
    @(negedge clk);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    for (int k = 0; k < 2000 && !got_bof; k++) begin
      flag_ready = stall ? k[0] : 1'b1;
      if (k == 2) begin
        if (mwr) begin len_wr_en = 1'b1; len_wr_data = mval; end
        if (mst) seq_start = 1'b1;
      end
      if (prev_wait && (!flag_valid || flag_data != prev_data)) hold_bad = 1;
      if (seq_done) early_done = 1;
      if (flag_valid && flag_ready) begin
        if (flag_data == 8'hFF) begin
          if (got_bof) order_bad = 1;
          nfill++;
        end else if (flag_data == 8'hC0) got_bof = 1;
        else order_bad = 1;
      end
      prev_wait = flag_valid && !flag_ready;
      prev_data = flag_data;
      @(negedge clk);
      len_wr_en = 1'b0;
      seq_start = 1'b0;
    end
    flag_ready = 1'b0;
    check(got_bof, req, got_bof, 1);
    check(nfill == exp_fill, req, nfill, exp_fill);
    check(!order_bad, "R2", order_bad, 0);
    if (stall) check(!hold_bad, "R5", hold_bad, 0);
    check(!early_done, "R7", early_done, 0);
    check(seq_done && !flag_valid, "R7", {seq_done, flag_valid}, 2);
    @(negedge clk);
    check(!seq_done && !flag_valid, "R8", {seq_done, flag_valid}, 0);
  endtask

  initial begin
    wait (cyc >= 190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!flag_valid && !seq_done, "R1", {flag_valid, seq_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!flag_valid && !seq_done, "R1", {flag_valid, seq_done}, 0);
    check(len_rd_data == 8'h00, "R9", len_rd_data, 0);
    // R1: register resets to 0, so an unwritten start sends 255 fillers
    run_frame(1'b0, 1'b0, 8'd0, 1'b0, 255, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v = VEC[i];
      if (v[28]) write_len(v[27:20]);
      run_frame(v[19], v[18], v[17:10], v[9], int'(v[8:0]), "R2");
    end

    // R5: ready held low for many cycles, valid and data must stay put
    write_len(8'd2);
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
    repeat (10) @(negedge clk);
    check(flag_valid && flag_data == 8'hFF, "R5", flag_data, 255);
    // R8: start while stalled does not restart the count
    seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
    flag_ready = 1'b1;
    @(negedge clk);
    check(flag_valid && flag_data == 8'hC0, "R8", flag_data, 192);
    @(negedge clk);
    flag_ready = 1'b0;
    check(seq_done && !flag_valid, "R7", seq_done, 1);
    @(negedge clk);
    check(!seq_done && !flag_valid, "R7", seq_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule